// File: doc/BRIEF.md
# Dirty Band Update Coalescer

This block turns a column of per-band "modified" flags from a frame buffer into a short list of full-width screen regions that need redrawing. Every flag stands for a band of `BAND_LINES` display lines (four by default). On a start pulse the block visits the bands from the top of the frame downward. For each band it presents the band number on a lookup port and reads back the flags for that band in the same cycle. Unbroken stretches of modified bands are merged into one region. Each region is handed out as a start line and a line count over a valid/ready handshake.

When the scan finishes, the block reports the first and last modified band so that the flag store can clear exactly that span, and then raises a one-cycle done pulse. In direct-colour mode a band also counts as modified when any of its sub-flags from the two wide planes is set. A force input makes every band count as modified, which redraws the whole screen.

Top module: `dirty_band_coalescer`

## Requirements
- R1: Band b covers lines b*BAND_LINES up to (b+1)*BAND_LINES-1. The first modified band after an unmodified stretch opens a region whose start line is b*BAND_LINES, so every emitted start line is a multiple of BAND_LINES.
- R2: An unmodified band b that follows an open region closes it. The emitted count is b*BAND_LINES minus the region's start line, and it is never zero.
- R3: The scan visits bands 0 to N-1, where N = ceil(frame_lines/BAND_LINES), limited to NUM_BANDS. A region still open after band N-1 is emitted with count N*BAND_LINES minus its start line, even when this passes frame_lines.
- R4: Any stretch of consecutive modified bands produces exactly one region, and regions are emitted in top-to-bottom order.
- R5: With direct_mode low, a band is modified only if idx_dirty is 1. The direct_dirty and ctrl_dirty inputs have no effect.
- R6: With direct_mode high, a band is modified if idx_dirty is 1, or if any bit of direct_dirty[SUB_FLAGS-1:0] is 1, or if any bit of ctrl_dirty[SUB_FLAGS-1:0] is 1.
- R7: With force_all high at start, every scanned band counts as modified. The result is one region from line 0 to N*BAND_LINES and a clear span from band 0 to band N-1.
- R8: clr_valid is high in the done cycle only if at least one band was modified. clr_first and clr_last are then the lowest and highest modified band numbers.
- R9: While rgn_valid is high and rgn_ready is low, the region outputs hold steady and the scan does not advance.
- R10: done is a single-cycle pulse raised after the last region has been accepted. A start pulse while busy is ignored.
- R11: After reset, busy, rgn_valid, done and clr_valid are all 0.
- R12: When frame_lines is 0, no band is scanned, no region is emitted, clr_valid stays 0 and done still pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a scan (taken only when idle) |
| direct_mode | input | 1 | Include the wide-plane sub-flags in the modified test |
| force_all | input | 1 | Treat every band as modified for this scan |
| frame_lines | input | LW | Display height in lines |
| scan_band | output | BW | Band number being looked up |
| idx_dirty | input | 1 | Indexed-plane flag of scan_band |
| direct_dirty | input | SUB_FLAGS | Direct-plane sub-flags of scan_band |
| ctrl_dirty | input | SUB_FLAGS | Control-plane sub-flags of scan_band |
| rgn_valid | output | 1 | Region offered |
| rgn_ready | input | 1 | Region accepted |
| rgn_line | output | LW | First line of the region |
| rgn_lines | output | LW | Number of lines in the region |
| clr_valid | output | 1 | Clear span valid (done cycle only) |
| clr_first | output | BW | Lowest modified band |
| clr_last | output | BW | Highest modified band |
| busy | output | 1 | Scan in progress |
| done | output | 1 | Scan finished pulse |

## Verification
The checks assume that frame_lines stays within NUM_BANDS*BAND_LINES. They also assume that the flag inputs answer for the band presented on scan_band in the same cycle and do not change during a scan. The bench holds its flag arrays fixed while a scan runs and returns them through a combinational lookup keyed on scan_band. It draws heights up to the full frame, including values that are not multiples of the band size. The ready line is randomised so that stalls of varying length occur, and one start pulse is injected in the middle of a scan.

// File: rtl/dbc_pkg.sv
package dbc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SCAN = 2'd1,
        ST_HOLD = 2'd2,
        ST_END  = 2'd3
    } dbc_state_e;

endpackage

// File: rtl/dbc_dirty_merge.sv
// Decides whether the band under lookup counts as modified.
module dbc_dirty_merge #(
    parameter int SUB_FLAGS = 4
) (
    input  logic                 direct_mode,
    input  logic                 force_dirty,
    input  logic                 idx_dirty,
    input  logic [SUB_FLAGS-1:0] direct_dirty,
    input  logic [SUB_FLAGS-1:0] ctrl_dirty,
    output logic                 band_dirty
);
    logic [SUB_FLAGS:0] wide_chain;

    assign wide_chain[0] = 1'b0;

    // OR chain over the sub-flags of both wide planes
    for (genvar k = 0; k < SUB_FLAGS; k++) begin : g_sub
        assign wide_chain[k+1] = wide_chain[k] | direct_dirty[k] | ctrl_dirty[k];
    end

    assign band_dirty = force_dirty | idx_dirty | (direct_mode & wide_chain[SUB_FLAGS]);

endmodule

// File: rtl/dbc_extent_track.sv
// Lowest and highest modified band seen since the last clear.
module dbc_extent_track #(
    parameter int BW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          hit,
    input  logic [BW-1:0] hit_band,
    output logic          seen,
    output logic [BW-1:0] low_band,
    output logic [BW-1:0] high_band
);
    typedef struct packed {
        logic          seen;
        logic [BW-1:0] low;
        logic [BW-1:0] high;
    } ext_t;

    ext_t ext_d, ext_q;

    always_comb begin
        ext_d = ext_q;
        if (clear) begin
            ext_d.seen = 1'b0;
        end else if (hit) begin
            if (!ext_q.seen || hit_band < ext_q.low) begin
                ext_d.low = hit_band;
            end
            if (!ext_q.seen || hit_band > ext_q.high) begin
                ext_d.high = hit_band;
            end
            ext_d.seen = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ext_q <= '0;
        end else begin
            ext_q <= ext_d;
        end
    end

    assign seen      = ext_q.seen;
    assign low_band  = ext_q.low;
    assign high_band = ext_q.high;

endmodule

// File: rtl/dirty_band_coalescer.sv
module dirty_band_coalescer
    import dbc_pkg::*;
#(
    parameter  int NUM_BANDS  = 192,
    parameter  int BAND_LINES = 4,
    parameter  int SUB_FLAGS  = 4,
    localparam int BW         = $clog2(NUM_BANDS + 1),
    localparam int LW         = $clog2(NUM_BANDS * BAND_LINES + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 direct_mode,
    input  logic                 force_all,
    input  logic [LW-1:0]        frame_lines,
    output logic [BW-1:0]        scan_band,
    input  logic                 idx_dirty,
    input  logic [SUB_FLAGS-1:0] direct_dirty,
    input  logic [SUB_FLAGS-1:0] ctrl_dirty,
    output logic                 rgn_valid,
    input  logic                 rgn_ready,
    output logic [LW-1:0]        rgn_line,
    output logic [LW-1:0]        rgn_lines,
    output logic                 clr_valid,
    output logic [BW-1:0]        clr_first,
    output logic [BW-1:0]        clr_last,
    output logic                 busy,
    output logic                 done
);
    localparam int MAX_LINES = NUM_BANDS * BAND_LINES;

    typedef struct packed {
        dbc_state_e    st;
        logic [BW-1:0] band;
        logic          run_open;
        logic [LW-1:0] run_start;
        logic [LW-1:0] lines_cfg;
        logic          mode;
        logic          force_dirty;
        logic [LW-1:0] out_line;
        logic [LW-1:0] out_len;
        logic          last;
    } seq_t;

    seq_t seq_d, seq_q;

    logic          band_dirty;
    logic          step_hit;
    logic          ext_clear;
    logic          ext_seen;
    logic [BW-1:0] ext_low;
    logic [BW-1:0] ext_high;
    logic [LW-1:0] line_now;
    logic          at_end;

    dbc_dirty_merge #(
        .SUB_FLAGS (SUB_FLAGS)
    ) u_merge (
        .direct_mode  (seq_q.mode),
        .force_dirty  (seq_q.force_dirty),
        .idx_dirty    (idx_dirty),
        .direct_dirty (direct_dirty),
        .ctrl_dirty   (ctrl_dirty),
        .band_dirty   (band_dirty)
    );

    dbc_extent_track #(
        .BW (BW)
    ) u_extent (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (ext_clear),
        .hit       (step_hit),
        .hit_band  (seq_q.band),
        .seen      (ext_seen),
        .low_band  (ext_low),
        .high_band (ext_high)
    );

    always_comb begin
        seq_d     = seq_q;
        step_hit  = 1'b0;
        ext_clear = 1'b0;
        line_now  = LW'(int'(seq_q.band) * BAND_LINES);
        at_end    = (seq_q.band == BW'(NUM_BANDS)) || (line_now >= seq_q.lines_cfg);

        unique case (seq_q.st)
            ST_IDLE: begin
                if (start) begin
                    ext_clear         = 1'b1;
                    seq_d.st          = ST_SCAN;
                    seq_d.band        = '0;
                    seq_d.run_open    = 1'b0;
                    seq_d.mode        = direct_mode;
                    seq_d.force_dirty = force_all;
                    seq_d.lines_cfg   = (frame_lines > LW'(MAX_LINES)) ? LW'(MAX_LINES)
                                                                       : frame_lines;
                end
            end

            ST_SCAN: begin
                if (at_end) begin
                    if (seq_q.run_open) begin
                        seq_d.out_line = seq_q.run_start;
                        seq_d.out_len  = line_now - seq_q.run_start;
                        seq_d.run_open = 1'b0;
                        seq_d.last     = 1'b1;
                        seq_d.st       = ST_HOLD;
                    end else begin
                        seq_d.st = ST_END;
                    end
                end else if (band_dirty) begin
                    step_hit   = 1'b1;
                    seq_d.band = seq_q.band + BW'(1);
                    if (!seq_q.run_open) begin
                        seq_d.run_open  = 1'b1;
                        seq_d.run_start = line_now;
                    end
                end else begin
                    seq_d.band = seq_q.band + BW'(1);
                    if (seq_q.run_open) begin
                        seq_d.out_line = seq_q.run_start;
                        seq_d.out_len  = line_now - seq_q.run_start;
                        seq_d.run_open = 1'b0;
                        seq_d.last     = 1'b0;
                        seq_d.st       = ST_HOLD;
                    end
                end
            end

            ST_HOLD: begin
                if (rgn_ready) begin
                    seq_d.st = seq_q.last ? ST_END : ST_SCAN;
                end
            end

            ST_END: begin
                seq_d.st = ST_IDLE;
            end

            default: begin
                seq_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign scan_band = seq_q.band;
    assign rgn_valid = (seq_q.st == ST_HOLD);
    assign rgn_line  = seq_q.out_line;
    assign rgn_lines = seq_q.out_len;
    assign done      = (seq_q.st == ST_END);
    assign clr_valid = (seq_q.st == ST_END) && ext_seen;
    assign clr_first = ext_low;
    assign clr_last  = ext_high;
    assign busy      = (seq_q.st != ST_IDLE);

endmodule

// File: rtl/dbc_checker.sv
module dbc_checker #(
    parameter  int NUM_BANDS  = 192,
    parameter  int BAND_LINES = 4,
    localparam int BW         = $clog2(NUM_BANDS + 1),
    localparam int LW         = $clog2(NUM_BANDS * BAND_LINES + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rgn_valid,
    input logic          rgn_ready,
    input logic [LW-1:0] rgn_line,
    input logic [LW-1:0] rgn_lines,
    input logic          clr_valid,
    input logic [BW-1:0] clr_first,
    input logic [BW-1:0] clr_last,
    input logic          busy,
    input logic          done
);

    assert_line_aligned_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rgn_valid |-> (int'(rgn_line) % BAND_LINES) == 0);

    assert_len_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rgn_valid |-> (rgn_lines != '0) && ((int'(rgn_lines) % BAND_LINES) == 0));

    assert_clear_span_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_valid |-> done && (clr_first <= clr_last) && (int'(clr_last) < NUM_BANDS));

    assert_hold_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rgn_valid && !rgn_ready) |=> rgn_valid && $stable(rgn_line) && $stable(rgn_lines));

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_quiet_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !rgn_valid && !done && !clr_valid);

endmodule

bind dirty_band_coalescer dbc_checker #(
    .NUM_BANDS  (NUM_BANDS),
    .BAND_LINES (BAND_LINES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rgn_valid (rgn_valid),
    .rgn_ready (rgn_ready),
    .rgn_line  (rgn_line),
    .rgn_lines (rgn_lines),
    .clr_valid (clr_valid),
    .clr_first (clr_first),
    .clr_last  (clr_last),
    .busy      (busy),
    .done      (done)
);

// File: tb/dirty_band_coalescer_test.sv
module dirty_band_coalescer_test;
    localparam int CLK_PERIOD = 10;
    localparam int NB  = 192;
    localparam int BL  = 4;
    localparam int SUB = 4;
    localparam int BW  = $clog2(NB + 1);
    localparam int LW  = $clog2(NB * BL + 1);

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start = 1'b0;
    logic           direct_mode = 1'b0;
    logic           force_all = 1'b0;
    logic [LW-1:0]  frame_lines = '0;
    logic [BW-1:0]  scan_band;
    logic           idx_dirty;
    logic [SUB-1:0] direct_dirty;
    logic [SUB-1:0] ctrl_dirty;
    logic           rgn_valid;
    logic           rgn_ready = 1'b0;
    logic [LW-1:0]  rgn_line;
    logic [LW-1:0]  rgn_lines;
    logic           clr_valid;
    logic [BW-1:0]  clr_first;
    logic [BW-1:0]  clr_last;
    logic           busy;
    logic           done;

    logic           f_idx [NB];
    logic [SUB-1:0] f_dir [NB];
    logic [SUB-1:0] f_ctl [NB];

    int exp_line [NB];
    int exp_len  [NB];
    int exp_n, exp_any, exp_lo, exp_hi;

    int vectors = 0;
    int errors  = 0;
    int cycles  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign idx_dirty    = (int'(scan_band) < NB) ? f_idx[int'(scan_band)] : 1'b0;
    assign direct_dirty = (int'(scan_band) < NB) ? f_dir[int'(scan_band)] : '0;
    assign ctrl_dirty   = (int'(scan_band) < NB) ? f_ctl[int'(scan_band)] : '0;

    dirty_band_coalescer #(
        .NUM_BANDS  (NB),
        .BAND_LINES (BL),
        .SUB_FLAGS  (SUB)
    ) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .direct_mode  (direct_mode),
        .force_all    (force_all),
        .frame_lines  (frame_lines),
        .scan_band    (scan_band),
        .idx_dirty    (idx_dirty),
        .direct_dirty (direct_dirty),
        .ctrl_dirty   (ctrl_dirty),
        .rgn_valid    (rgn_valid),
        .rgn_ready    (rgn_ready),
        .rgn_line     (rgn_line),
        .rgn_lines    (rgn_lines),
        .clr_valid    (clr_valid),
        .clr_first    (clr_first),
        .clr_last     (clr_last),
        .busy         (busy),
        .done         (done)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            errors++;
            vectors++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    function automatic bit band_mod(input int b, input bit dm, input bit fa);
        return fa || f_idx[b] || (dm && ((|f_dir[b]) || (|f_ctl[b])));
    endfunction

    // Reference model of the scan, from the requirements
    task automatic build_expect(input int lines, input bit dm, input bit fa);
        int nb;
        int st;
        bit open;
        nb = (lines + BL - 1) / BL;
        if (nb > NB) nb = NB;
        exp_n = 0; exp_any = 0; exp_lo = 0; exp_hi = 0;
        open = 0; st = 0;
        for (int b = 0; b < nb; b++) begin
            if (band_mod(b, dm, fa)) begin
                if (!exp_any) exp_lo = b;
                exp_hi = b;
                exp_any = 1;
                if (!open) begin open = 1; st = b * BL; end
            end else if (open) begin
                exp_line[exp_n] = st; exp_len[exp_n] = b * BL - st; exp_n++;
                open = 0;
            end
        end
        if (open) begin
            exp_line[exp_n] = st; exp_len[exp_n] = nb * BL - st; exp_n++;
        end
    endtask

    task automatic fill(input int mode_sel, input int density);
        for (int b = 0; b < NB; b++) begin
            f_idx[b] = 1'b0; f_dir[b] = '0; f_ctl[b] = '0;
            case (mode_sel)
                0: ;
                1: f_idx[b] = 1'b1;
                2: f_idx[b] = ($urandom % 100) < density;
                3: begin
                    f_idx[b] = ($urandom % 100) < density;
                    if (($urandom % 100) < density) f_dir[b][$urandom % SUB] = 1'b1;
                    if (($urandom % 100) < density) f_ctl[b][$urandom % SUB] = 1'b1;
                end
                default: f_idx[b] = b[0];
            endcase
        end
    endtask

    task automatic run_scan(input int lines, input bit dm, input bit fa,
                            input int ready_pct, input bit poke, input string req);
        int got;
        int guard;
        bit finished;
        build_expect(lines, dm, fa);
        @(negedge clk);
        frame_lines = LW'(lines);
        direct_mode = dm;
        force_all   = fa;
        start       = 1'b1;
        @(negedge clk);
        start = 1'b0;
        got = 0; guard = 0; finished = 0;
        while (!finished && guard < 20000) begin
            guard++;
            rgn_ready = (($urandom % 100) < ready_pct);
            if (poke && guard == 5) start = 1'b1;
            else start = 1'b0;
            if (rgn_valid && rgn_ready) begin
                if (got < exp_n) begin
                    check(int'(rgn_line) == exp_line[got], req, "region start line",
                          int'(rgn_line), exp_line[got]);
                    check(int'(rgn_lines) == exp_len[got], req, "region line count",
                          int'(rgn_lines), exp_len[got]);
                end else begin
                    check(0, req, "extra region count", got + 1, exp_n);
                end
                got++;
            end
            if (done) begin
                finished = 1;
                check(int'(clr_valid) == exp_any, "R8", "clear valid", int'(clr_valid), exp_any);
                if (exp_any) begin
                    check(int'(clr_first) == exp_lo, "R8", "clear first band",
                          int'(clr_first), exp_lo);
                    check(int'(clr_last) == exp_hi, "R8", "clear last band",
                          int'(clr_last), exp_hi);
                end
                check(got == exp_n, req, "regions emitted", got, exp_n);
            end
            @(negedge clk);
        end
        start = 1'b0;
        rgn_ready = 1'b0;
        check(finished, "R10", "scan reached done", int'(finished), 1);
        check(!done && !busy, "R10", "done single pulse then idle", int'(done), 0);
    endtask

    initial begin
        void'($urandom(32'd1234));
        fill(0, 0);
        repeat (3) @(negedge clk);
        check(!busy && !rgn_valid && !done && !clr_valid, "R11", "reset outputs quiet",
              int'(busy) + int'(rgn_valid) + int'(done) + int'(clr_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);

        fill(2, 40);
        run_scan(0, 0, 0, 100, 0, "R12");
        fill(0, 0);
        run_scan(NB * BL, 0, 0, 100, 0, "R4");
        fill(1, 0);
        run_scan(NB * BL, 0, 0, 60, 0, "R4");
        fill(4, 0);
        run_scan(NB * BL, 0, 0, 100, 0, "R2");
        fill(1, 0);
        run_scan(10, 0, 0, 100, 0, "R3");
        fill(0, 0);
        f_idx[NB-1] = 1'b1;
        run_scan(NB * BL, 0, 0, 100, 0, "R3");
        fill(0, 0);
        f_idx[0] = 1'b1;
        run_scan(NB * BL, 0, 0, 100, 0, "R1");
        fill(0, 0);
        for (int b = 5; b < 40; b++) f_dir[b] = 4'b0100;
        for (int b = 60; b < 64; b++) f_ctl[b] = 4'b0001;
        run_scan(NB * BL, 0, 0, 100, 0, "R5");
        run_scan(NB * BL, 1, 0, 100, 0, "R6");
        fill(0, 0);
        run_scan(301, 0, 1, 100, 0, "R7");
        fill(2, 30);
        run_scan(NB * BL, 0, 0, 20, 0, "R9");
        fill(2, 50);
        run_scan(NB * BL, 0, 0, 70, 1, "R10");

        for (int i = 0; i < 24; i++) begin
            fill(2 + (i % 2), 10 + int'($urandom % 70));
            run_scan(int'($urandom % (NB * BL + 1)), bit'(i % 2), 1'b0,
                     30 + int'($urandom % 71), 1'b0, "R4");
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule